// File: doc/BRIEF.md
# Sync Correction Word Timing Controller

This block keeps the word-boundary phase of a serial-to-parallel receiver. The phase is a bit position from 0 to WORD_BITS-1 that decides where parallel words are cut from the serial stream. An upstream pattern detector reports each timing sync it finds, with a one-cycle strobe and the bit offset where that sync landed. The block compares that offset with the phase it holds. A sync that lands somewhere else counts as a sync error.

A correction-enable input sets how an error is handled. With correction on, one isolated misaligned sync is tolerated: the phase is kept and an error is marked as pending. The phase moves to the new offset only when the next valid sync is also misaligned. A sync that matches the phase clears the pending mark. With correction off, every misaligned sync moves the phase at once.

Each error gives a one-clock error pulse. A leaky counter tracks the recent error rate: it goes up by a fixed step on each error and down by one on each good sync. It drives a warning flag that has separate set and clear thresholds, so the flag has hysteresis. The flag takes the place of an analog RC filter and Schmitt comparator.

Top module: `sync_align_ctrl`

## Requirements
- R1: After reset, phase_o is 0, sync_err_o is 0 and warn_o is 0. The error-rate count and the pending mark are both zero.
- R2: A valid sync whose offset equals phase_o gives no error pulse. It leaves phase_o unchanged and clears the pending mark, so the next misaligned sync under correction is tolerated again.
- R3: Each valid misaligned sync raises sync_err_o for exactly the one clock after the strobe. sync_err_o is 0 in every clock that does not follow a misaligned sync.
- R4: With corr_en_i=1 and no error pending, a misaligned sync leaves phase_o unchanged and marks an error as pending.
- R5: With corr_en_i=1 and an error pending, a misaligned sync loads its offset into phase_o and clears the pending mark.
- R6: With corr_en_i=0, every misaligned sync loads its offset into phase_o. It also clears the pending mark.
- R7: A strobe whose offset is WORD_BITS or more is ignored. It changes neither phase_o nor the pending mark nor the rate count, and it gives no error pulse.
- R8: The rate count rises by ERR_STEP on each error and saturates at RATE_MAX. It falls by 1 on each good sync and saturates at 0.
- R9: warn_o becomes 1 when the rate count reaches SET_TH or more. It becomes 0 when the count falls to CLR_TH or less. Between the two thresholds it keeps its value. SET_TH must be greater than CLR_TH.
- R10: All outputs change in the clock after the strobe that causes the change. The reset input is asynchronous and active low, and its release is synchronised over two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_det_i | input | 1 | One-cycle strobe: a sync was detected |
| sync_ofs_i | input | OFS_W (4) | Bit offset of the detected sync |
| corr_en_i | input | 1 | 1: tolerate one isolated error; 0: realign on every error |
| phase_o | output | OFS_W (4) | Current word-boundary phase |
| sync_err_o | output | 1 | One-clock pulse for each misaligned sync |
| warn_o | output | 1 | Error-rate warning flag with hysteresis |

## Verification
Two things can happen on the same strobe. A second consecutive misaligned sync under correction realigns the phase, and its rate step can push the warning flag over its set threshold in that same clock. Directed runs of back-to-back misaligned syncs bring this about, starting from a rate count just below SET_TH. Long random streams also bring it about, with corr_en_i toggled between strobes. A bench model of phase, pending mark and rate count checks phase_o, sync_err_o and warn_o together in the clock after each strobe.

// File: rtl/sync_align_pkg.sv
package sync_align_pkg;
  // Decision taken for one strobe
  typedef enum logic [1:0] {
    ACT_IGNORE   = 2'd0,
    ACT_ACCEPT   = 2'd1,
    ACT_TOLERATE = 2'd2,
    ACT_REALIGN  = 2'd3
  } sync_act_e;
endpackage

// File: rtl/sync_classify.sv
module sync_classify
  import sync_align_pkg::*;
#(
  parameter int WORD_BITS = 10,
  localparam int OFS_W = $clog2(WORD_BITS)
) (
  input  logic             sync_det,
  input  logic [OFS_W-1:0] sync_ofs,
  input  logic [OFS_W-1:0] phase,
  input  logic             pend,
  input  logic             corr_en,
  output sync_act_e        act
);
  logic valid;

  always_comb begin
    valid = sync_det && (32'(sync_ofs) < WORD_BITS);
    if (!valid)                act = ACT_IGNORE;
    else if (sync_ofs == phase) act = ACT_ACCEPT;
    else if (corr_en && !pend) act = ACT_TOLERATE;
    else                       act = ACT_REALIGN;
  end
endmodule

// File: rtl/phase_track.sv
module phase_track
  import sync_align_pkg::*;
#(
  parameter int WORD_BITS = 10,
  localparam int OFS_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  sync_act_e        act,
  input  logic [OFS_W-1:0] sync_ofs,
  output logic [OFS_W-1:0] phase_q,
  output logic             pend_q,
  output logic             err_q
);
  logic [OFS_W-1:0] phase_d;
  logic             pend_d;
  logic             err_d;
  logic             upd_en;

  always_comb begin
    phase_d = phase_q;
    pend_d  = pend_q;
    err_d   = 1'b0;
    upd_en  = (act != ACT_IGNORE);
    unique case (act)
      ACT_ACCEPT:   pend_d = 1'b0;
      ACT_TOLERATE: begin
        pend_d = 1'b1;
        err_d  = 1'b1;
      end
      ACT_REALIGN:  begin
        phase_d = sync_ofs;
        pend_d  = 1'b0;
        err_d   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (upd_en) begin
        phase_q <= phase_d;
        pend_q  <= pend_d;
      end
    end
  end
endmodule

// File: rtl/err_rate.sv
module err_rate #(
  parameter int ERR_STEP = 4,
  parameter int RATE_MAX = 15,
  parameter int SET_TH   = 8,
  parameter int CLR_TH   = 3,
  localparam int RATE_W  = $clog2(RATE_MAX + 1),
  localparam int SUM_W   = RATE_W + 1
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              good,
  input  logic              bad,
  output logic [RATE_W-1:0] rate_q,
  output logic              warn_q
);
  logic [SUM_W-1:0]  sum;
  logic [RATE_W-1:0] rate_d;
  logic              warn_d;
  logic              upd_en;

  always_comb begin
    upd_en = good | bad;
    sum    = {1'b0, rate_q} + SUM_W'(ERR_STEP);
    rate_d = rate_q;
    if (bad) begin
      rate_d = (sum > SUM_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : sum[RATE_W-1:0];
    end else if (good) begin
      rate_d = (rate_q == '0) ? '0 : rate_q - 1'b1;
    end
    warn_d = warn_q;
    if (rate_d >= RATE_W'(SET_TH))      warn_d = 1'b1;
    else if (rate_d <= RATE_W'(CLR_TH)) warn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rate_q <= '0;
      warn_q <= 1'b0;
    end else if (upd_en) begin
      rate_q <= rate_d;
      warn_q <= warn_d;
    end
  end
endmodule

// File: rtl/sync_align_ctrl.sv
module sync_align_ctrl
  import sync_align_pkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int ERR_STEP  = 4,
  parameter int RATE_MAX  = 15,
  parameter int SET_TH    = 8,
  parameter int CLR_TH    = 3,
  localparam int OFS_W    = $clog2(WORD_BITS),
  localparam int RATE_W   = $clog2(RATE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_det_i,
  input  logic [OFS_W-1:0] sync_ofs_i,
  input  logic             corr_en_i,
  output logic [OFS_W-1:0] phase_o,
  output logic             sync_err_o,
  output logic             warn_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  sync_act_e         act;
  logic              pend;
  logic [RATE_W-1:0] rate;
  logic              good;
  logic              bad;

  // Reset asserts at once and is released two clocks later (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  sync_classify #(.WORD_BITS(WORD_BITS)) u_classify (
    .sync_det (sync_det_i),
    .sync_ofs (sync_ofs_i),
    .phase    (phase_o),
    .pend     (pend),
    .corr_en  (corr_en_i),
    .act      (act)
  );

  phase_track #(.WORD_BITS(WORD_BITS)) u_track (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .act      (act),
    .sync_ofs (sync_ofs_i),
    .phase_q  (phase_o),
    .pend_q   (pend),
    .err_q    (sync_err_o)
  );

  assign good = (act == ACT_ACCEPT);
  assign bad  = (act == ACT_TOLERATE) || (act == ACT_REALIGN);

  err_rate #(
    .ERR_STEP (ERR_STEP),
    .RATE_MAX (RATE_MAX),
    .SET_TH   (SET_TH),
    .CLR_TH   (CLR_TH)
  ) u_rate (
    .clk    (clk),
    .rst_sn (rst_sn),
    .good   (good),
    .bad    (bad),
    .rate_q (rate),
    .warn_q (warn_o)
  );
endmodule

// File: rtl/sync_align_ctrl_chk.sv
module sync_align_ctrl_chk #(
  parameter int WORD_BITS = 10,
  parameter int RATE_MAX  = 15,
  parameter int SET_TH    = 8,
  parameter int CLR_TH    = 3,
  localparam int OFS_W    = $clog2(WORD_BITS),
  localparam int RATE_W   = $clog2(RATE_MAX + 1)
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              sync_det_i,
  input logic [OFS_W-1:0]  sync_ofs_i,
  input logic              corr_en_i,
  input logic [OFS_W-1:0]  phase_o,
  input logic              sync_err_o,
  input logic              warn_o,
  input logic              pend,
  input logic [RATE_W-1:0] rate
);
  logic vld;
  assign vld = sync_det_i && (32'(sync_ofs_i) < WORD_BITS);

  assert_match_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i == phase_o |=> !sync_err_o && !pend && $stable(phase_o));

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i != phase_o |=> sync_err_o);

  assert_no_err_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    !sync_det_i |=> !sync_err_o);

  assert_tolerate_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i != phase_o && corr_en_i && !pend |=> $stable(phase_o) && pend);

  assert_second_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i != phase_o && corr_en_i && pend
    |=> phase_o == $past(sync_ofs_i) && !pend);

  assert_realign_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i != phase_o && !corr_en_i |=> phase_o == $past(sync_ofs_i));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    sync_det_i && !vld |=> $stable(phase_o) && $stable(rate) && $stable(pend) && !sync_err_o);

  assert_rate_bound_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    32'(rate) <= RATE_MAX);

  assert_decay_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    vld && sync_ofs_i == phase_o && rate != '0 |=> rate == $past(rate) - 1'b1);

  assert_warn_set_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    32'(rate) >= SET_TH |-> warn_o);

  assert_warn_clr_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    32'(rate) <= CLR_TH |-> !warn_o);
endmodule

bind sync_align_ctrl sync_align_ctrl_chk #(
  .WORD_BITS (WORD_BITS),
  .RATE_MAX  (RATE_MAX),
  .SET_TH    (SET_TH),
  .CLR_TH    (CLR_TH)
) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .sync_det_i (sync_det_i),
  .sync_ofs_i (sync_ofs_i),
  .corr_en_i  (corr_en_i),
  .phase_o    (phase_o),
  .sync_err_o (sync_err_o),
  .warn_o     (warn_o),
  .pend       (pend),
  .rate       (rate)
);

// File: tb/sync_align_ctrl_bench.sv
module sync_align_ctrl_bench;
  localparam int WB = 10, STEP = 4, RMAX = 15, SET = 8, CLR = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_det_i = 1'b0;
  logic [3:0] sync_ofs_i = '0;
  logic       corr_en_i = 1'b1;
  logic [3:0] phase_o;
  logic       sync_err_o;
  logic       warn_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_ph = 0, m_rate = 0;
  bit m_pend = 0, m_warn = 0, m_err = 0;

  always #4 clk = ~clk;

  sync_align_ctrl u_sync_align_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_det_i(sync_det_i), .sync_ofs_i(sync_ofs_i),
    .corr_en_i(corr_en_i), .phase_o(phase_o), .sync_err_o(sync_err_o), .warn_o(warn_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rate_up(int r);
    return (r + STEP > RMAX) ? RMAX : r + STEP;
  endfunction

  function automatic int rate_dn(int r);
    return (r == 0) ? 0 : r - 1;
  endfunction

  function automatic bit warn_next(int r, bit w);
    if (r >= SET) return 1'b1;
    if (r <= CLR) return 1'b0;
    return w;
  endfunction

  // One strobe (or idle when det=0), then check outputs one clock later (R10)
  task automatic step(bit det, int ofs, bit en, string wtag);
    string ptag;
    @(negedge clk);
    sync_det_i = det;
    sync_ofs_i = 4'(ofs);
    corr_en_i  = en;
    ptag = "R10";
    m_err = 0;
    if (det && ofs >= WB) ptag = "R7";
    else if (det) begin
      if (ofs == m_ph) begin
        ptag = "R2"; m_pend = 0; m_rate = rate_dn(m_rate);
      end else begin
        m_err = 1; m_rate = rate_up(m_rate);
        if (!en)        begin ptag = "R6"; m_ph = ofs; m_pend = 0; end
        else if (m_pend) begin ptag = "R5"; m_ph = ofs; m_pend = 0; end
        else            begin ptag = "R4"; m_pend = 1; end
      end
      m_warn = warn_next(m_rate, m_warn);
    end
    @(negedge clk);
    sync_det_i = 1'b0;
    chk({ptag, " phase"}, int'(phase_o), m_ph);
    chk("R3 sync_err", int'(sync_err_o), int'(m_err));
    chk({wtag, " warn"}, int'(warn_o), int'(m_warn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 sync_err", int'(sync_err_o), 0);
    chk("R1 warn", int'(warn_o), 0);

    // directed: correction enabled
    step(1, 0, 1, "R9");      // R2 match
    step(1, 5, 1, "R9");      // R4 tolerate
    step(0, 0, 1, "R9");      // R3 pulse ends
    step(1, 7, 1, "R9");      // R5 realign to 7, rate 8 -> warn set
    step(1, 7, 1, "R9");      // R2 match, rate 7, warn held
    step(1, 3, 1, "R9");      // R4 tolerate
    step(1, 7, 1, "R9");      // R2 clears pending
    step(1, 2, 1, "R9");      // R4 tolerated again after clear
    step(0, 0, 0, "R9");
    step(1, 4, 0, "R9");      // R6 immediate realign
    step(1, 12, 1, "R7");     // R7 invalid offset ignored
    step(1, 15, 0, "R7");
    // saturation and hysteresis
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 1 : 6, 0, "R8");
    for (int i = 0; i < 14; i++) step(1, m_ph, 1, "R9");
    step(1, m_ph, 1, "R8");   // decay floor
    // back-to-back errors crossing SET with realign in same clock
    step(1, 9, 1, "R9");
    step(1, 8, 1, "R9");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      int o;
      bit d = (r < 80);
      if (r < 40) o = m_ph;
      else if (r < 75) o = int'($urandom_range(0, WB - 1));
      else o = int'($urandom_range(WB, 15));
      step(d, o, bit'($urandom_range(0, 1)), "R9");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule